// File: doc/BRIEF.md
# Parallel camera grayscale capture

This block sits between a parallel-output image sensor and an on-chip frame store. The sensor delivers two bytes per pixel on an 8-bit bus, qualified by a line-valid signal and framed by a vertical sync pulse. The block keeps only the first byte of every pair, which carries luma, and emits one 8-bit gray sample per pixel. Each sample comes with its column, its row and its linear offset in the frame, ready to drive a RAM write port. Storing gray only keeps a 320 by 240 frame small enough that two complete frames fit in on-chip memory.

Capture is gated per frame. The capture-enable input is looked at only when vertical sync rises, and the whole frame that follows is either written or ignored. At the next vertical sync rise, the frame that just ended is judged. If exactly the configured number of lines, each with exactly the configured number of pixels, was received, a frame-done pulse is given. Otherwise an error pulse is given. The block also produces the sensor's input clock by dividing its reference clock.

The pixel side runs on the sensor's pixel clock. The reference side runs on the reference clock. Each side releases the shared asynchronous reset through its own synchronizer. The capture-enable input is taken as already synchronous to the pixel clock.

Top module: `cam_gray_capture`

## Requirements
- R1: While reset is asserted, and until the first qualifying input after reset, wr_en, frame_start, frame_done, frame_err and cam_xclk are all 0.
- R2: cam_xclk is a square wave that changes level every XCLK_DIV/2 ref_clk cycles. With the default XCLK_DIV of 4, a 100 MHz reference gives 25 MHz.
- R3: While a frame is being captured and cam_href is 1, incoming bytes alternate between luma and chroma, and each line starts with luma. Each luma byte produces exactly one wr_en pulse carrying that byte on wr_data, in the pclk cycle after it is sampled. Chroma bytes produce no write.
- R4: A write carries the column on wr_x (0 to WIDTH-1), the line on wr_y (0 to HEIGHT-1) and the linear offset wr_addr = wr_y*WIDTH + wr_x (0 to WIDTH*HEIGHT-1). The defaults are WIDTH 320 and HEIGHT 240, so the offset runs from 0 to 76799.
- R5: A rising edge of cam_vsync resets column, line and byte phase. If cap_en is 1 at that edge, the frame is captured and frame_start pulses for one cycle. If cap_en is 0, there is no frame_start and no write until the next vsync rise.
- R6: Bytes sampled while cam_href is 0 are ignored. The line counter advances on the falling edge of cam_href.
- R7: At a vsync rise that ends a captured frame, frame_done pulses for one cycle if exactly HEIGHT lines, each of exactly WIDTH pixels (2*WIDTH bytes), were received.
- R8: At a vsync rise that ends a captured frame with a wrong line count or a wrong pixel count in any line, frame_err pulses instead of frame_done. frame_done and frame_err are never high together.
- R9: A pixel beyond column WIDTH-1, or on a line beyond HEIGHT-1, produces no write.
- R10: Two writes are never in consecutive pclk cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock for the sensor clock divider |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_en | input | 1 | Capture enable, sampled at each vsync rise |
| cam_xclk | output | 1 | Clock driven to the sensor |
| cam_pclk | input | 1 | Pixel clock from the sensor |
| cam_vsync | input | 1 | Vertical sync, a rising edge starts a frame |
| cam_href | input | 1 | Line valid, high while bytes of a line arrive |
| cam_data | input | 8 | Sensor byte bus |
| wr_en | output | 1 | Gray sample write strobe |
| wr_addr | output | $clog2(WIDTH*HEIGHT) | Linear pixel offset |
| wr_x | output | $clog2(WIDTH+1) | Pixel column |
| wr_y | output | $clog2(HEIGHT+1) | Pixel line |
| wr_data | output | 8 | Gray sample |
| frame_start | output | 1 | One-cycle pulse when a captured frame begins |
| frame_done | output | 1 | One-cycle pulse for a complete, well-formed frame |
| frame_err | output | 1 | One-cycle pulse for a malformed frame |

## Verification
The luma selection is driven with distinct values in the luma and chroma bytes, so a swapped byte phase shows up as a wrong wr_data. Frames with the exact geometry are mixed with frames that are one line short, one line long, or have one line with an extra pixel. This separates frame_done from frame_err and also shows that out-of-range pixels are never written. Idle bytes with href low between lines, and a frame started with cap_en low, show whether gating and line advance follow href and the vsync-time enable.

// File: rtl/cgc_pkg.sv
package cgc_pkg;
  typedef enum logic {
    PH_LUMA   = 1'b0,
    PH_CHROMA = 1'b1
  } byte_phase_t;

  typedef struct packed {
    logic       vs_rise;
    logic       hs_fall;
    logic       href;
    logic [7:0] data;
  } cam_evt_t;
endpackage

// File: rtl/cgc_rst_sync.sv
module cgc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/cgc_xclk_gen.sv
module cgc_xclk_gen #(
  parameter int XCLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic xclk
);
  localparam int HALF = XCLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          xclk_d;
  logic          wrap;

  assign wrap = (cnt_q == CW'(HALF - 1));

  always_comb begin
    cnt_d  = wrap ? '0 : cnt_q + 1'b1;
    xclk_d = wrap ? ~xclk : xclk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      xclk  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      xclk  <= xclk_d;
    end
  end
endmodule

// File: rtl/cgc_sync_edges.sv
module cgc_sync_edges
  import cgc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vsync,
  input  logic       href,
  input  logic [7:0] data,
  output cam_evt_t   evt
);
  logic vs_q, hs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q <= 1'b0;
      hs_q <= 1'b0;
    end else begin
      vs_q <= vsync;
      hs_q <= href;
    end
  end

  always_comb begin
    evt.vs_rise = vsync & ~vs_q;
    evt.hs_fall = ~href & hs_q;
    evt.href    = href;
    evt.data    = data;
  end
endmodule

// File: rtl/cgc_pixel_track.sv
module cgc_pixel_track
  import cgc_pkg::*;
#(
  parameter int WIDTH  = 320,
  parameter int HEIGHT = 240
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cap_en,
  input  cam_evt_t                      evt,
  output logic                          wr_en,
  output logic [$clog2(WIDTH*HEIGHT)-1:0] wr_addr,
  output logic [$clog2(WIDTH+1)-1:0]    wr_x,
  output logic [$clog2(HEIGHT+1)-1:0]   wr_y,
  output logic [7:0]                    wr_data,
  output logic                          frame_start,
  output logic                          frame_done,
  output logic                          frame_err
);
  localparam int XW = $clog2(WIDTH + 1);
  localparam int YW = $clog2(HEIGHT + 1);
  localparam int AW = $clog2(WIDTH * HEIGHT);
  localparam int BW = $clog2(WIDTH * HEIGHT + 1);
  localparam logic [XW-1:0] X_END = XW'(WIDTH);
  localparam logic [YW-1:0] Y_END = YW'(HEIGHT);

  logic              active_q, active_d;
  logic              bad_q, bad_d;
  byte_phase_t       phase_q, phase_d;
  logic [XW-1:0]     x_q, x_d;
  logic [YW-1:0]     y_q, y_d;
  logic [BW-1:0]     base_q, base_d;
  logic [BW-1:0]     lin;

  logic              wr_en_d, start_d, done_d, err_d;
  logic [AW-1:0]     addr_d;
  logic [XW-1:0]     wx_d;
  logic [YW-1:0]     wy_d;
  logic [7:0]        wd_d;

  assign lin = base_q + BW'(x_q);

  always_comb begin
    active_d = active_q;
    bad_d    = bad_q;
    phase_d  = phase_q;
    x_d      = x_q;
    y_d      = y_q;
    base_d   = base_q;
    wr_en_d  = 1'b0;
    start_d  = 1'b0;
    done_d   = 1'b0;
    err_d    = 1'b0;
    addr_d   = wr_addr;
    wx_d     = wr_x;
    wy_d     = wr_y;
    wd_d     = wr_data;

    if (evt.vs_rise) begin
      if (active_q) begin
        if (!bad_q && (y_q == Y_END)) done_d = 1'b1;
        else                          err_d  = 1'b1;
      end
      active_d = cap_en;
      start_d  = cap_en;
      bad_d    = 1'b0;
      phase_d  = PH_LUMA;
      x_d      = '0;
      y_d      = '0;
      base_d   = '0;
    end else if (active_q) begin
      if (evt.href) begin
        if (phase_q == PH_LUMA) begin
          if ((x_q < X_END) && (y_q < Y_END)) begin
            wr_en_d = 1'b1;
            addr_d  = lin[AW-1:0];
            wx_d    = x_q;
            wy_d    = y_q;
            wd_d    = evt.data;
          end else begin
            bad_d = 1'b1;
          end
          phase_d = PH_CHROMA;
        end else begin
          phase_d = PH_LUMA;
          if (x_q != X_END) x_d = x_q + 1'b1;
        end
      end else if (evt.hs_fall) begin
        if ((x_q != X_END) || (phase_q != PH_LUMA)) bad_d = 1'b1;
        x_d     = '0;
        phase_d = PH_LUMA;
        if (y_q < Y_END) begin
          y_d    = y_q + 1'b1;
          base_d = base_q + BW'(WIDTH);
        end else begin
          bad_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      bad_q       <= 1'b0;
      phase_q     <= PH_LUMA;
      x_q         <= '0;
      y_q         <= '0;
      base_q      <= '0;
      wr_en       <= 1'b0;
      wr_addr     <= '0;
      wr_x        <= '0;
      wr_y        <= '0;
      wr_data     <= '0;
      frame_start <= 1'b0;
      frame_done  <= 1'b0;
      frame_err   <= 1'b0;
    end else begin
      active_q    <= active_d;
      bad_q       <= bad_d;
      phase_q     <= phase_d;
      x_q         <= x_d;
      y_q         <= y_d;
      base_q      <= base_d;
      wr_en       <= wr_en_d;
      frame_start <= start_d;
      frame_done  <= done_d;
      frame_err   <= err_d;
      if (wr_en_d) begin
        wr_addr <= addr_d;
        wr_x    <= wx_d;
        wr_y    <= wy_d;
        wr_data <= wd_d;
      end
    end
  end
endmodule

// File: rtl/cam_gray_capture.sv
module cam_gray_capture
  import cgc_pkg::*;
#(
  parameter int WIDTH    = 320,
  parameter int HEIGHT   = 240,
  parameter int XCLK_DIV = 4
) (
  input  logic                            ref_clk,
  input  logic                            rst_n,
  input  logic                            cap_en,
  output logic                            cam_xclk,
  input  logic                            cam_pclk,
  input  logic                            cam_vsync,
  input  logic                            cam_href,
  input  logic [7:0]                      cam_data,
  output logic                            wr_en,
  output logic [$clog2(WIDTH*HEIGHT)-1:0] wr_addr,
  output logic [$clog2(WIDTH+1)-1:0]      wr_x,
  output logic [$clog2(HEIGHT+1)-1:0]     wr_y,
  output logic [7:0]                      wr_data,
  output logic                            frame_start,
  output logic                            frame_done,
  output logic                            frame_err
);
  logic     ref_rst_n;
  logic     pix_rst_n;
  cam_evt_t evt;

  cgc_rst_sync u_ref_rst (
    .clk        (ref_clk),
    .rst_n      (rst_n),
    .rst_sync_n (ref_rst_n)
  );

  cgc_rst_sync u_pix_rst (
    .clk        (cam_pclk),
    .rst_n      (rst_n),
    .rst_sync_n (pix_rst_n)
  );

  cgc_xclk_gen #(.XCLK_DIV(XCLK_DIV)) u_xclk (
    .clk   (ref_clk),
    .rst_n (ref_rst_n),
    .xclk  (cam_xclk)
  );

  cgc_sync_edges u_edges (
    .clk   (cam_pclk),
    .rst_n (pix_rst_n),
    .vsync (cam_vsync),
    .href  (cam_href),
    .data  (cam_data),
    .evt   (evt)
  );

  cgc_pixel_track #(.WIDTH(WIDTH), .HEIGHT(HEIGHT)) u_track (
    .clk         (cam_pclk),
    .rst_n       (pix_rst_n),
    .cap_en      (cap_en),
    .evt         (evt),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_x        (wr_x),
    .wr_y        (wr_y),
    .wr_data     (wr_data),
    .frame_start (frame_start),
    .frame_done  (frame_done),
    .frame_err   (frame_err)
  );
endmodule

// File: rtl/cgc_checker.sv
module cgc_checker #(
  parameter int WIDTH  = 320,
  parameter int HEIGHT = 240
) (
  input logic                            cam_pclk,
  input logic                            rst_n,
  input logic                            cap_en,
  input logic                            wr_en,
  input logic [$clog2(WIDTH*HEIGHT)-1:0] wr_addr,
  input logic [$clog2(WIDTH+1)-1:0]      wr_x,
  input logic [$clog2(HEIGHT+1)-1:0]     wr_y,
  input logic                            frame_start,
  input logic                            frame_done,
  input logic                            frame_err
);
  p_addr_linear_r4: assert property (@(posedge cam_pclk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) == int'(wr_y) * WIDTH + int'(wr_x)));

  p_in_range_r9: assert property (@(posedge cam_pclk) disable iff (!rst_n)
    wr_en |-> ((int'(wr_x) < WIDTH) && (int'(wr_y) < HEIGHT)));

  p_no_back_to_back_r10: assert property (@(posedge cam_pclk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  p_done_xor_err_r8: assert property (@(posedge cam_pclk) disable iff (!rst_n)
    !(frame_done && frame_err));

  p_start_needs_en_r5: assert property (@(posedge cam_pclk) disable iff (!rst_n)
    frame_start |-> $past(cap_en));

  p_start_single_r5: assert property (@(posedge cam_pclk) disable iff (!rst_n)
    frame_start |=> !frame_start);
endmodule

bind cam_gray_capture cgc_checker #(.WIDTH(WIDTH), .HEIGHT(HEIGHT)) u_cgc_checker (
  .cam_pclk    (cam_pclk),
  .rst_n       (rst_n),
  .cap_en      (cap_en),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_x        (wr_x),
  .wr_y        (wr_y),
  .frame_start (frame_start),
  .frame_done  (frame_done),
  .frame_err   (frame_err)
);

// File: tb/cam_gray_capture_bench.sv
`timescale 1ns/1ps
module cam_gray_capture_bench;
  localparam int W   = 8;
  localparam int H   = 4;
  localparam int DIV = 4;
  localparam int AW  = $clog2(W*H);
  localparam int XW  = $clog2(W+1);
  localparam int YW  = $clog2(H+1);

  logic          clk;
  logic          rst_n;
  logic          cap_en;
  logic          xclk;
  logic          vsync, href;
  logic [7:0]    data;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [XW-1:0] wr_x;
  logic [YW-1:0] wr_y;
  logic [7:0]    wr_data;
  logic          f_start, f_done, f_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  cam_gray_capture #(.WIDTH(W), .HEIGHT(H), .XCLK_DIV(DIV)) u_cam_gray_capture (
    .ref_clk     (clk),
    .rst_n       (rst_n),
    .cap_en      (cap_en),
    .cam_xclk    (xclk),
    .cam_pclk    (clk),
    .cam_vsync   (vsync),
    .cam_href    (href),
    .cam_data    (data),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_x        (wr_x),
    .wr_y        (wr_y),
    .wr_data     (wr_data),
    .frame_start (f_start),
    .frame_done  (f_done),
    .frame_err   (f_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] luma(input int x, input int y);
    return 8'((y * 16 + x) ^ 8'h5A);
  endfunction

  // drive one pixel-clock byte, then sample just after the capturing edge
  task automatic step(input logic vs, input logic hr, input logic [7:0] d);
    @(negedge clk);
    vsync = vs; href = hr; data = d;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; cap_en = 1'b0; vsync = 1'b0; href = 1'b0; data = '0;
    repeat (4) @(posedge clk);
    #1;
    chk(!wr_en && !f_start && !f_done && !f_err, "R1 outputs in reset", int'(wr_en), 0);
    chk(xclk == 1'b0, "R1 xclk in reset", int'(xclk), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) step(1'b0, 1'b0, 8'h00);
    chk(!wr_en && !f_start && !f_done && !f_err, "R1 outputs idle after reset", int'(f_start), 0);
  endtask

  task automatic t_xclk;
    logic prev;
    int   cnt;
    @(posedge clk); #1;
    prev = xclk;
    while (xclk == prev) begin @(posedge clk); #1; end
    for (int k = 0; k < 4; k++) begin
      prev = xclk; cnt = 0;
      while (xclk == prev) begin @(posedge clk); #1; cnt++; end
      chk(cnt == DIV/2, "R2 xclk half period", cnt, DIV/2);
    end
  endtask

  task automatic vs_pulse(input logic en, input bit exp_start, input bit exp_done, input bit exp_err);
    @(negedge clk); cap_en = en;
    step(1'b1, 1'b0, 8'h00);
    chk(f_start == exp_start, "R5 frame_start at vsync", int'(f_start), int'(exp_start));
    chk(f_done == exp_done, "R7 frame_done at vsync", int'(f_done), int'(exp_done));
    chk(f_err == exp_err, "R8 frame_err at vsync", int'(f_err), int'(exp_err));
    step(1'b1, 1'b0, 8'h00);
    chk(!f_start && !f_done && !f_err, "R5 pulses last one cycle", int'(f_start | f_done | f_err), 0);
    step(1'b0, 1'b0, 8'h00);
  endtask

  task automatic send_line(input int y, input int npix, input bit en);
    bit exp_wr;
    for (int x = 0; x < npix; x++) begin
      exp_wr = en && (x < W) && (y < H);
      step(1'b0, 1'b1, luma(x, y));
      chk(wr_en == exp_wr, exp_wr ? "R3 luma write" : "R9/R5 no write", int'(wr_en), int'(exp_wr));
      if (exp_wr) begin
        chk(wr_data == luma(x, y), "R3 luma byte kept", int'(wr_data), int'(luma(x, y)));
        chk(int'(wr_x) == x && int'(wr_y) == y, "R4 x/y", int'(wr_x) * 100 + int'(wr_y), x * 100 + y);
        chk(int'(wr_addr) == y * W + x, "R4 linear address", int'(wr_addr), y * W + x);
      end
      step(1'b0, 1'b1, 8'hC3 ^ 8'(x));
      chk(!wr_en, "R3 chroma dropped R10", int'(wr_en), 0);
    end
    // line end and idle bytes with href low
    step(1'b0, 1'b0, 8'hEE);
    chk(!wr_en, "R6 href low ignored", int'(wr_en), 0);
    step(1'b0, 1'b0, 8'h11);
    chk(!wr_en, "R6 href low ignored", int'(wr_en), 0);
  endtask

  task automatic send_frame(input int nlines, input int wide_line, input bit en);
    for (int y = 0; y < nlines; y++)
      send_line(y, (y == wide_line) ? W + 1 : W, en);
  endtask

  task automatic t_good_frames;
    vs_pulse(1'b1, 1, 0, 0);
    send_frame(H, -1, 1);
    vs_pulse(1'b1, 1, 1, 0);   // R7 complete frame
  endtask

  task automatic t_short_frame;
    send_frame(H - 1, -1, 1);
    vs_pulse(1'b1, 1, 0, 1);   // R8 too few lines
  endtask

  task automatic t_wide_line;
    send_frame(H, 1, 1);       // R9 extra pixel not written
    vs_pulse(1'b1, 1, 0, 1);   // R8 wrong pixel count
  endtask

  task automatic t_long_frame;
    send_frame(H + 1, -1, 1);  // R9 extra line not written
    vs_pulse(1'b0, 0, 0, 1);   // R8 too many lines; R5 disabled start
  endtask

  task automatic t_disabled_frame;
    send_frame(H, -1, 0);      // R5 no writes while disabled
    vs_pulse(1'b1, 1, 0, 0);   // no verdict for an uncaptured frame
    send_frame(H, -1, 1);
    vs_pulse(1'b1, 1, 1, 0);
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #200000;
    chk(0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    t_reset();
    t_xclk();
    t_good_frames();
    t_short_frame();
    t_wide_line();
    t_long_frame();
    t_disabled_frame();
    report();
  end
endmodule